// File: doc/BRIEF.md
# Operand fetch register file

This block holds the integer architectural state of a 64-bit load/store core and produces both source operands for the execute stage. Each cycle it takes two source indices and returns their register contents on two combinational read ports. The second operand can instead come from an 8-bit immediate carried in the instruction, widened with zero bits. A single write port commits one result per cycle on the rising clock edge.

The highest index is the constant-zero register. Reading it always returns zero, and a write aimed at it is thrown away. A result written in the same cycle that a port reads the same register is forwarded to that port, so the decode stage never sees a stale value. The program counter is not part of this storage and has no read path here.

Top module: `opf_regfile`

## Requirements
- R1: The file holds 32 registers of 64 bits, indices 0 to 31. Port A returns, combinationally, the contents of the register selected by `rs_a_idx`.
- R2: When either source index is 31, that operand reads as 64'h0, no matter what was written to index 31.
- R3: A write with `wr_idx` = 31 is discarded and leaves every register unchanged.
- R4: With `lit_sel` = 1, `opnd_b` equals `{56'b0, lit_val}`, and the register selected by `rs_b_idx` has no effect on it.
- R5: With `lit_sel` = 0, `opnd_b` returns the register selected by `rs_b_idx`, under the same rules as port A.
- R6: A synchronous active-high `rst` clears all registers to zero on the rising edge. A write requested while `rst` is high is ignored.
- R7: When `wr_en` = 1, `rst` = 0, `wr_idx` is not 31 and a source index equals `wr_idx` in the same cycle, that operand equals `wr_data`.
- R8: A write commits on the rising edge and reads back from the next cycle on. While `wr_en` = 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write commits on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rs_a_idx | input | 5 | Source index for operand A |
| rs_b_idx | input | 5 | Source index for operand B |
| lit_sel | input | 1 | 1 selects the immediate for operand B |
| lit_val | input | 8 | Immediate value, zero-extended when selected |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Destination index |
| wr_data | input | 64 | Write data |
| opnd_a | output | 64 | Operand A |
| opnd_b | output | 64 | Operand B (register or immediate) |

## Verification
A corrupted register entry stays hidden until something reads it. It then shows as a wrong operand in the same combinational cycle the index is presented, so the bench reads every index against its own model, not just the ones written recently. A leak into the zero entry is visible on any read of index 31. A missing forward shows only in the exact cycle where the read and write indices match. A write that lands in the wrong slot shows one cycle later, on both the slot it hit and the slot it missed.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam int unsigned OPF_NREGS = 32;
    localparam int unsigned OPF_XLEN  = 64;
    localparam int unsigned OPF_LITW  = 8;

    // Source of the second operand
    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_LIT = 1'b1
    } opnd_src_e;

endpackage

// File: rtl/opf_store.sv
module opf_store #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned XLEN  = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [$clog2(NREGS)-1:0]        widx,
    input  logic [XLEN-1:0]                 wdata,
    output logic [NREGS-1:0][XLEN-1:0]      regs_o
);

    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (we) begin
            st_d.regs[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    // R6: every entry is zero one edge after reset
    p_reset_clears_r6: assert property (@(posedge clk)
        rst |=> (st_q.regs == '0));

    // R8: an accepted write is present in its slot on the next cycle
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> (st_q.regs[$past(widx)] == $past(wdata)));

    // R8: no write request, no change of state
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(st_q.regs));

    // R3: the constant-zero slot is never filled
    p_zero_slot_clean_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.regs[NREGS-1] == '0);

endmodule

// File: rtl/opf_read_port.sv
module opf_read_port #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned XLEN  = 64
) (
    input  logic [$clog2(NREGS)-1:0]        idx,
    input  logic [NREGS-1:0][XLEN-1:0]      regs,
    input  logic                            byp_en,
    input  logic [$clog2(NREGS)-1:0]        byp_idx,
    input  logic [XLEN-1:0]                 byp_data,
    output logic [XLEN-1:0]                 data
);

    localparam int unsigned        IDXW     = $clog2(NREGS);
    localparam logic [IDXW-1:0]    ZERO_IDX = IDXW'(NREGS - 1);

    always_comb begin
        data = regs[idx];
        if (byp_en && (byp_idx == idx)) begin
            data = byp_data;
        end
        if (idx == ZERO_IDX) begin
            data = '0;
        end
    end

endmodule

// File: rtl/opf_operand_mux.sv
module opf_operand_mux
    import opf_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned LITW = 8
) (
    input  opnd_src_e           src,
    input  logic [XLEN-1:0]     reg_val,
    input  logic [LITW-1:0]     lit,
    output logic [XLEN-1:0]     opnd
);

    localparam int unsigned PADW = XLEN - LITW;

    always_comb begin
        unique case (src)
            SRC_LIT: opnd = {{PADW{1'b0}}, lit};
            default: opnd = reg_val;
        endcase
    end

endmodule

// File: rtl/opf_regfile.sv
module opf_regfile
    import opf_pkg::*;
#(
    parameter int unsigned NREGS = OPF_NREGS,
    parameter int unsigned XLEN  = OPF_XLEN,
    parameter int unsigned LITW  = OPF_LITW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(NREGS)-1:0]    rs_a_idx,
    input  logic [$clog2(NREGS)-1:0]    rs_b_idx,
    input  logic                        lit_sel,
    input  logic [LITW-1:0]             lit_val,
    input  logic                        wr_en,
    input  logic [$clog2(NREGS)-1:0]    wr_idx,
    input  logic [XLEN-1:0]             wr_data,
    output logic [XLEN-1:0]             opnd_a,
    output logic [XLEN-1:0]             opnd_b
);

    localparam int unsigned        IDXW     = $clog2(NREGS);
    localparam int unsigned        NRD      = 2;
    localparam int unsigned        PADW     = XLEN - LITW;
    localparam logic [IDXW-1:0]    ZERO_IDX = IDXW'(NREGS - 1);

    logic                          wr_commit;
    logic [NREGS-1:0][XLEN-1:0]    regs;
    logic [NRD-1:0][IDXW-1:0]      rd_idx;
    logic [NRD-1:0][XLEN-1:0]      rd_val;
    opnd_src_e                     b_src;

    // Writes are accepted only outside reset and away from the zero slot
    assign wr_commit = wr_en && !rst && (wr_idx != ZERO_IDX);

    opf_store #(
        .NREGS (NREGS),
        .XLEN  (XLEN)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_commit),
        .widx   (wr_idx),
        .wdata  (wr_data),
        .regs_o (regs)
    );

    assign rd_idx = {rs_b_idx, rs_a_idx};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        opf_read_port #(
            .NREGS (NREGS),
            .XLEN  (XLEN)
        ) u_rd (
            .idx      (rd_idx[p]),
            .regs     (regs),
            .byp_en   (wr_commit),
            .byp_idx  (wr_idx),
            .byp_data (wr_data),
            .data     (rd_val[p])
        );
    end

    assign b_src = lit_sel ? SRC_LIT : SRC_REG;

    opf_operand_mux #(
        .XLEN (XLEN),
        .LITW (LITW)
    ) u_bmux (
        .src     (b_src),
        .reg_val (rd_val[1]),
        .lit     (lit_val),
        .opnd    (opnd_b)
    );

    assign opnd_a = rd_val[0];

    // R2: zero register reads as zero on either port
    p_zero_read_a_r2: assert property (@(posedge clk) disable iff (rst)
        (rs_a_idx == ZERO_IDX) |-> (opnd_a == '0));
    p_zero_read_b_r2: assert property (@(posedge clk) disable iff (rst)
        (!lit_sel && rs_b_idx == ZERO_IDX) |-> (opnd_b == '0));

    // R4: immediate is zero-extended onto operand B
    p_literal_zext_r4: assert property (@(posedge clk) disable iff (rst)
        lit_sel |-> (opnd_b == {{PADW{1'b0}}, lit_val}));

    // R5: register path reaches operand B when the immediate is off
    p_reg_b_path_r5: assert property (@(posedge clk) disable iff (rst)
        !lit_sel |-> (opnd_b == rd_val[1]));

    // R7: same-cycle forward of the write data
    p_bypass_a_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != ZERO_IDX && rs_a_idx == wr_idx) |-> (opnd_a == wr_data));

endmodule

// File: tb/sim_opf_regfile.sv
`timescale 1ns/1ps
module sim_opf_regfile;

    localparam real HALF = 2.5;
    localparam int  VW   = 89;
    localparam int  NV   = 14;

    // {wr_en, wr_idx[5], wr_data[64], rs_a[5], rs_b[5], lit_sel, lit_val[8]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 5'd1,  64'h0123_4567_89ab_cdef, 5'd0,  5'd1,  1'b0, 8'h00},
        {1'b1, 5'd2,  64'hffff_0000_ffff_0000, 5'd1,  5'd2,  1'b0, 8'h00},
        {1'b0, 5'd0,  64'h0,                   5'd1,  5'd2,  1'b0, 8'h00},
        {1'b1, 5'd31, 64'hdead_beef_dead_beef, 5'd31, 5'd31, 1'b0, 8'h00},
        {1'b0, 5'd0,  64'h0,                   5'd31, 5'd1,  1'b0, 8'h00},
        {1'b0, 5'd0,  64'h0,                   5'd2,  5'd2,  1'b1, 8'hff},
        {1'b0, 5'd0,  64'h0,                   5'd1,  5'd31, 1'b1, 8'h5a},
        {1'b1, 5'd7,  64'h8000_0000_0000_0001, 5'd7,  5'd7,  1'b0, 8'h00},
        {1'b1, 5'd7,  64'h1111_2222_3333_4444, 5'd7,  5'd3,  1'b1, 8'h80},
        {1'b0, 5'd9,  64'haaaa_aaaa_aaaa_aaaa, 5'd9,  5'd7,  1'b0, 8'h00},
        {1'b1, 5'd30, 64'h7fff_ffff_ffff_ffff, 5'd0,  5'd30, 1'b0, 8'h00},
        {1'b1, 5'd0,  64'h0000_0000_0000_00aa, 5'd0,  5'd30, 1'b0, 8'h00},
        {1'b1, 5'd31, 64'h1,                   5'd0,  5'd31, 1'b0, 8'h00},
        {1'b0, 5'd0,  64'h0,                   5'd0,  5'd30, 1'b1, 8'h01}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rs_a_idx, rs_b_idx, wr_idx;
    logic        lit_sel, wr_en;
    logic [7:0]  lit_val;
    logic [63:0] wr_data, opnd_a, opnd_b;

    logic [63:0] ref_regs [32];
    int          n_cmp = 0;
    int          n_bad = 0;

    always #(HALF) clk = ~clk;

    opf_regfile u0 (
        .clk      (clk),
        .rst      (rst),
        .rs_a_idx (rs_a_idx),
        .rs_b_idx (rs_b_idx),
        .lit_sel  (lit_sel),
        .lit_val  (lit_val),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [4:0] idx, input logic we,
                                               input logic [4:0] wi, input logic [63:0] wd);
        if (idx == 5'd31) return 64'h0;
        if (we && wi == idx) return wd;
        return ref_regs[idx];
    endfunction

    // One cycle: drive at negedge, compare mid-cycle, commit at posedge
    task automatic step(input logic we, input logic [4:0] wi, input logic [63:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb,
                        input logic ls, input logic [7:0] lv,
                        input string tag_a, input string tag_b);
        logic [63:0] ea, eb;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd;
        rs_a_idx = ra; rs_b_idx = rb; lit_sel = ls; lit_val = lv;
        #1;
        ea = model_read(ra, we, wi, wd);
        eb = ls ? {56'h0, lv} : model_read(rb, we, wi, wd);
        check(tag_a, opnd_a, ea);
        check(tag_b, opnd_b, eb);
        @(posedge clk);
        if (we && wi != 5'd31) ref_regs[wi] = wd;
    endtask

    task automatic do_reset(input logic we_during);
        @(negedge clk);
        rst = 1'b1; wr_en = we_during; wr_idx = 5'd5; wr_data = 64'hcafe_f00d_0000_0005;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) ref_regs[i] = 64'h0;
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        rs_a_idx = '0; rs_b_idx = '0; lit_sel = 1'b0; lit_val = '0;
        for (int i = 0; i < 32; i++) ref_regs[i] = 64'h0;
        repeat (2) @(posedge clk);
        do_reset(1'b0);

        // R6: every register reads zero after reset
        for (int i = 0; i < 32; i += 2)
            step(1'b0, 5'd0, 64'h0, 5'(i), 5'(i + 1), 1'b0, 8'h0, "R6 reset a", "R6 reset b");

        // Vector table: R1 R2 R3 R4 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] t;
            t = VEC[v];
            step(t[88], t[87:83], t[82:19], t[18:14], t[13:9], t[8], t[7:0],
                 "R1/R2/R7 table a", "R4/R5 table b");
        end

        // R3: write to 31 then read every register; none disturbed
        step(1'b1, 5'd31, 64'hffff_ffff_ffff_ffff, 5'd31, 5'd31, 1'b0, 8'h0, "R3 a", "R3 b");
        for (int i = 0; i < 32; i += 2)
            step(1'b0, 5'd0, 64'h0, 5'(i), 5'(i + 1), 1'b0, 8'h0, "R3 sweep a", "R3 sweep b");

        // R4: literal ignores a nonzero register on rs_b
        step(1'b0, 5'd0, 64'h0, 5'd1, 5'd1, 1'b1, 8'hc3, "R4 a", "R4 literal");
        // R7: forward on both ports at once, lit off
        step(1'b1, 5'd12, 64'h5555_6666_7777_8888, 5'd12, 5'd12, 1'b0, 8'h0, "R7 a", "R7 b");
        // R8: wr_en low does not disturb, then next-cycle visibility
        step(1'b0, 5'd12, 64'h0, 5'd12, 5'd12, 1'b0, 8'h0, "R8 hold a", "R8 hold b");

        // Random traffic incl. index 31 (R1 R2 R3 R5 R7)
        for (int k = 0; k < 600; k++) begin
            logic [4:0] wi, ra, rb;
            wi = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 32);
            ra = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 32);
            rb = ($urandom % 3 == 0) ? wi : 5'($urandom % 32);
            step(($urandom % 4) != 0, wi, {$urandom, $urandom}, ra, rb,
                 ($urandom % 4) == 0, 8'($urandom), "R1 random a", "R5 random b");
        end

        // R6: write requested during reset is ignored, and reset clears state
        step(1'b1, 5'd5, 64'h1234, 5'd5, 5'd5, 1'b0, 8'h0, "R6 pre a", "R6 pre b");
        do_reset(1'b1);
        step(1'b0, 5'd0, 64'h0, 5'd5, 5'd12, 1'b0, 8'h0, "R6 write in reset", "R6 cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule